// File: doc/BRIEF.md
# DMA Channel Event and Loop Control Register Bank

This block is the shared control register bank of a sixteen-channel DMA controller. It collects the completion and half-buffer event pulses raised by the channel engines, latches them as per-channel pending flags, masks them with a per-channel enable, and folds the result into one registered interrupt line toward the processor. It also holds the loop-mode control word and turns writes to a stop register into one-cycle stop pulses for the channel engines.

Software reaches the block through a simple memory-mapped port with a write strobe and a read strobe. Pending flags are cleared by writing ones. The enable word and the loop word can each be changed two ways: by writing the whole value, or by writing ones to a separate clear alias. The alias lets one channel's driver clear its own bits without a read-modify-write that could race with another channel's driver. Each channel's loop control uses two bits, bit n and bit n+16, and a channel loops only while both are set. The per-channel address, length and width registers sit elsewhere in the controller.

Top module: `dmac_evt_ctl`

## Requirements
- R1: After reset every register reads zero, and `irq`, `loop_run` and `ch_stop` are all zero.
- R2: A one-cycle pulse on `done_evt[n]` or `half_evt[n]` sets pending bit n, which reads back as bit n of offset 0x144.
- R3: Writing to 0x144 clears exactly the pending bits written as 1. All other pending bits keep their value.
- R4: If an event pulse and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Offset 0x148 holds the interrupt enable word. A write replaces bits [15:0], and the bits above 15 always read zero.
- R6: Writing to 0x14C clears the enable bits written as 1 and leaves the other enable bits unchanged. A read of 0x14C returns zero.
- R7: `irq` is high in the cycle after some channel has both its pending bit and its enable bit set. It goes low in the cycle after no channel meets that condition.
- R8: Offset 0x150 is the 32-bit loop word, written whole and read back whole. `loop_run[n]` is high exactly while loop bits n and n+16 are both 1.
- R9: Writing to 0x15C clears the loop bits written as 1 and leaves the others unchanged. A read of 0x15C returns zero.
- R10: Writing a value with bit n set to 0x140 drives `ch_stop[n]` high for exactly the one cycle after the write. A read of 0x140 returns zero.
- R11: Read data is registered. `reg_rdata` shows the addressed value in the cycle after `reg_rd`. It is zero for an unmapped address, and zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| done_evt | input | 16 | Per-channel transfer-complete pulses |
| half_evt | input | 16 | Per-channel half-buffer pulses |
| irq | output | 1 | Combined registered interrupt |
| loop_run | output | 16 | Per-channel loop-running level |
| ch_stop | output | 16 | Per-channel one-cycle stop pulses |

## Verification
The assertions assume that reset is held low for at least two clock edges. They also assume that every input is at a known value from the first clock edge on, so the values that `$past` looks back at are defined. They treat `reg_wr` and `reg_rd` as independent strobes, and they do not assume the event pulses are kept apart from clear writes. The stimulus holds reset for several cycles with every input at zero, and it changes inputs only at falling edges. It deliberately drives an event and a clear to the same bit in the same cycle, so the collision rule is exercised and not avoided.

// File: rtl/dmac_evt_pkg.sv
// Package: shared offsets, read-select codes and write strobes for the DMA
// event and loop control bank. Assumes byte addressing with word-aligned
// registers.
package dmac_evt_pkg;

    localparam int unsigned OFS_STOP     = 32'h140;
    localparam int unsigned OFS_PEND     = 32'h144;
    localparam int unsigned OFS_IEN      = 32'h148;
    localparam int unsigned OFS_IEN_CLR  = 32'h14C;
    localparam int unsigned OFS_LOOP     = 32'h150;
    localparam int unsigned OFS_LOOP_CLR = 32'h15C;

    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_PEND = 2'd1,
        RSEL_IEN  = 2'd2,
        RSEL_LOOP = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic pend_w1c;
        logic ien_wr;
        logic ien_clr;
        logic loop_wr;
        logic loop_clr;
        logic stop_wr;
    } wr_stb_t;

endpackage

// File: rtl/dmac_evt_decode.sv
// Module: address decoder. Turns the write strobe and offset into one
// strobe per register and picks the read source. Assumes offsets fit in
// ADDR_W bits. Aliases and the stop register select zero on reads.
module dmac_evt_decode
    import dmac_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_stb_t           stb,
    output rd_sel_e           sel
);

    // Decode offset into write strobes and read select.
    always_comb begin
        stb = '0;
        sel = RSEL_ZERO;
        case (addr)
            ADDR_W'(OFS_PEND): begin
                stb.pend_w1c = wr;
                sel          = RSEL_PEND;
            end
            ADDR_W'(OFS_IEN): begin
                stb.ien_wr = wr;
                sel        = RSEL_IEN;
            end
            ADDR_W'(OFS_IEN_CLR):  stb.ien_clr  = wr;
            ADDR_W'(OFS_LOOP): begin
                stb.loop_wr = wr;
                sel         = RSEL_LOOP;
            end
            ADDR_W'(OFS_LOOP_CLR): stb.loop_clr = wr;
            ADDR_W'(OFS_STOP):     stb.stop_wr  = wr;
            default: ;
        endcase
    end

endmodule

// File: rtl/dmac_irq_bank.sv
// Module: pending flags, interrupt enables and the combined interrupt.
// Each channel has one pending flag. The flag is set by its event input
// and cleared by a write-one. If both arrive together, the set wins.
// Assumes event inputs are synchronous to clk.
module dmac_irq_bank #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_set,
    input  logic           pend_w1c,
    input  logic           ien_wr,
    input  logic           ien_clr,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] pending,
    output logic [NCH-1:0] enable,
    output logic           irq
);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Pending flag: set beats write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                     pending[n] <= 1'b0;
            else if (evt_set[n])            pending[n] <= 1'b1;
            else if (pend_w1c && wbits[n])  pending[n] <= 1'b0;
        end

        // Enable bit: whole write or clear alias.
        always_ff @(posedge clk) begin
            if (!rst_n)                     enable[n] <= 1'b0;
            else if (ien_wr)                enable[n] <= wbits[n];
            else if (ien_clr && wbits[n])   enable[n] <= 1'b0;
        end
    end

    // Combined interrupt, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pending & enable);
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((pending & $past(evt_set)) == $past(evt_set))); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w1c && ((evt_set & wbits) != '0)) |=>
        ((pending & $past(evt_set & wbits)) == $past(evt_set & wbits))); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w1c |=> ((pending & $past(wbits & ~evt_set)) == '0)); // R3
    AST_IEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_clr && !ien_wr) |=> ((enable & $past(wbits)) == '0)); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & enable) != '0) |=> irq); // R7
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & enable) == '0) |=> !irq); // R7

endmodule

// File: rtl/dmac_loop_bank.sv
// Module: loop control pairs and stop pulses. Channel n has a low bit at
// n and a high bit at n+HI_OFS, and loops only while both are set.
// A write to the stop register makes a one-cycle pulse for each bit
// written as 1. Assumes NCH <= HI_OFS and HI_OFS + NCH <= DW.
module dmac_loop_bank #(
    parameter int unsigned NCH    = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned HI_OFS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           loop_wr,
    input  logic           loop_clr,
    input  logic           stop_wr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  loop_word,
    output logic [NCH-1:0] loop_run,
    output logic [NCH-1:0] stop_pulse
);

    logic [NCH-1:0] lo_q;
    logic [NCH-1:0] hi_q;

    for (genvar n = 0; n < NCH; n++) begin : g_pair
        // Low half of the pair.
        always_ff @(posedge clk) begin
            if (!rst_n)                    lo_q[n] <= 1'b0;
            else if (loop_wr)              lo_q[n] <= wdata[n];
            else if (loop_clr && wdata[n]) lo_q[n] <= 1'b0;
        end

        // High half of the pair.
        always_ff @(posedge clk) begin
            if (!rst_n)                             hi_q[n] <= 1'b0;
            else if (loop_wr)                       hi_q[n] <= wdata[n+HI_OFS];
            else if (loop_clr && wdata[n+HI_OFS])   hi_q[n] <= 1'b0;
        end

        assign loop_run[n] = lo_q[n] & hi_q[n];
    end

    // Assemble the readable loop word.
    always_comb begin
        loop_word = '0;
        loop_word[NCH-1:0]         = lo_q;
        loop_word[HI_OFS +: NCH]   = hi_q;
    end

    // One-cycle stop pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)       stop_pulse <= '0;
        else if (stop_wr) stop_pulse <= wdata[NCH-1:0];
        else              stop_pulse <= '0;
    end

    AST_LOOP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        loop_wr |=> (loop_run == ($past(wdata[NCH-1:0]) & $past(wdata[HI_OFS +: NCH])))); // R8
    AST_LOOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_clr && !loop_wr) |=> ((loop_word & $past(wdata)) == '0)); // R9
    AST_STOP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse != '0) |-> $past(stop_wr)); // R10
    AST_STOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_wr) |=> (stop_pulse == '0)); // R10

endmodule

// File: rtl/dmac_evt_ctl.sv
// Module: top of the DMA event and loop control bank. Merges the two
// event sources per channel, decodes the register port and registers the
// read data. Assumes a single register master, with reg_wr and reg_rd
// synchronous to clk.
module dmac_evt_ctl
    import dmac_evt_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NCH-1:0]    done_evt,
    input  logic [NCH-1:0]    half_evt,
    output logic              irq,
    output logic [NCH-1:0]    loop_run,
    output logic [NCH-1:0]    ch_stop
);

    localparam int unsigned HI_OFS = DW / 2;

    wr_stb_t        stb;
    rd_sel_e        sel;
    logic [NCH-1:0] pending;
    logic [NCH-1:0] enable;
    logic [DW-1:0]  loop_word;
    logic [NCH-1:0] evt_any;

    // Either event source raises the channel's pending flag.
    assign evt_any = done_evt | half_evt;

    dmac_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (reg_wr),
        .addr (reg_addr),
        .stb  (stb),
        .sel  (sel)
    );

    dmac_irq_bank #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_any),
        .pend_w1c (stb.pend_w1c),
        .ien_wr   (stb.ien_wr),
        .ien_clr  (stb.ien_clr),
        .wbits    (reg_wdata[NCH-1:0]),
        .pending  (pending),
        .enable   (enable),
        .irq      (irq)
    );

    dmac_loop_bank #(.NCH(NCH), .DW(DW), .HI_OFS(HI_OFS)) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_wr    (stb.loop_wr),
        .loop_clr   (stb.loop_clr),
        .stop_wr    (stb.stop_wr),
        .wdata      (reg_wdata),
        .loop_word  (loop_word),
        .loop_run   (loop_run),
        .stop_pulse (ch_stop)
    );

    // Registered read mux; zero when idle or unmapped.
    always_ff @(posedge clk) begin
        if (!rst_n || !reg_rd) begin
            reg_rdata <= '0;
        end else begin
            case (sel)
                RSEL_PEND: reg_rdata <= DW'(pending);
                RSEL_IEN:  reg_rdata <= DW'(enable);
                RSEL_LOOP: reg_rdata <= loop_word;
                default:   reg_rdata <= '0;
            endcase
        end
    end

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |=> (reg_rdata == '0)); // R11
    AST_RD_NOEVT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(OFS_IEN_CLR))) |=> (reg_rdata == '0)); // R6

endmodule

// File: tb/dmac_evt_ctl_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the DMA event and loop control bank.
module dmac_evt_ctl_tb;

    localparam int NCH = 16;
    localparam int DW  = 32;
    localparam int AW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NCH-1:0] done_evt = '0;
    logic [NCH-1:0] half_evt = '0;
    logic          irq;
    logic [NCH-1:0] loop_run;
    logic [NCH-1:0] ch_stop;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmac_evt_ctl #(.NCH(NCH), .DW(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_evt(done_evt), .half_evt(half_evt), .irq(irq),
        .loop_run(loop_run), .ch_stop(ch_stop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] hf);
        done_evt = dn; half_evt = hf;
        @(negedge clk);
        done_evt = '0; half_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 loop_run", 32'(loop_run), 32'd0);
        check("R1 ch_stop", 32'(ch_stop), 32'd0);
        rd(12'h144, v); check("R1 pending", v, 32'd0);
        rd(12'h148, v); check("R1 enable", v, 32'd0);
        rd(12'h150, v); check("R1 loop", v, 32'd0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse(16'h0008, 16'h0200);
        rd(12'h144, v); check("R2 set by both event kinds", v, 32'h0000_0208);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(12'h144, 32'h0000_0008);
        rd(12'h144, v); check("R3 clear one bit", v, 32'h0000_0200);
        wr(12'h144, 32'h0000_0200);
        rd(12'h144, v); check("R3 clear last bit", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        pulse(16'h0020, 16'h0000);
        done_evt = 16'h0020;
        wr(12'h144, 32'h0000_0020);
        done_evt = '0;
        rd(12'h144, v); check("R4 set wins over clear", v, 32'h0000_0020);
        wr(12'h144, 32'h0000_0020);
        rd(12'h144, v); check("R4 later clear works", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(12'h148, 32'hFFFF_FFFF);
        rd(12'h148, v); check("R5 upper bits zero", v, 32'h0000_FFFF);
        wr(12'h148, 32'h0000_00A5);
        rd(12'h148, v); check("R5 whole write", v, 32'h0000_00A5);
    endtask

    task automatic t_enable_clr();
        logic [31:0] v;
        wr(12'h14C, 32'h0000_0005);
        rd(12'h148, v); check("R6 alias clears written ones", v, 32'h0000_00A0);
        rd(12'h14C, v); check("R6 alias reads zero", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pulse(16'h0002, 16'h0000);
        @(negedge clk);
        check("R7 disabled channel no irq", {31'd0, irq}, 32'd0);
        wr(12'h144, 32'h0000_0002);
        pulse(16'h0080, 16'h0000);
        check("R7 irq lags one cycle", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R7 irq asserted", {31'd0, irq}, 32'd1);
        wr(12'h144, 32'h0000_0080);
        check("R7 irq still high at clear edge", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R7 irq released", {31'd0, irq}, 32'd0);
        rd(12'h144, v); check("R7 pending empty", v, 32'h0);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        wr(12'h150, 32'h0001_0001);
        check("R8 pair set runs", 32'(loop_run), 32'h0001);
        wr(12'h150, 32'h0000_0002);
        check("R8 half pair idle", 32'(loop_run), 32'h0000);
        wr(12'h150, 32'h0006_0006);
        check("R8 two channels run", 32'(loop_run), 32'h0006);
        rd(12'h150, v); check("R8 readback", v, 32'h0006_0006);
    endtask

    task automatic t_loop_clr();
        logic [31:0] v;
        wr(12'h15C, 32'h0004_0000);
        check("R9 one half cleared pauses", 32'(loop_run), 32'h0002);
        rd(12'h150, v); check("R9 others kept", v, 32'h0002_0006);
        rd(12'h15C, v); check("R9 alias reads zero", v, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(12'h140, 32'h0000_0010);
        check("R10 stop pulse", 32'(ch_stop), 32'h0010);
        @(negedge clk);
        check("R10 pulse one cycle", 32'(ch_stop), 32'h0000);
        rd(12'h140, v); check("R10 stop reads zero", v, 32'h0);
    endtask

    task automatic t_read_path();
        logic [31:0] v;
        rd(12'h100, v); check("R11 unmapped reads zero", v, 32'h0);
        rd(12'h000, v); check("R11 offset zero unmapped", v, 32'h0);
        reg_rd = 1'b1; reg_addr = 12'h148;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R11 data one cycle after strobe", reg_rdata, 32'h0000_00A0);
        @(negedge clk);
        check("R11 zero when idle", reg_rdata, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_collide();
        t_enable();
        t_enable_clr();
        t_irq();
        t_loop();
        t_loop_clr();
        t_stop();
        t_read_path();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule